// File: doc/BRIEF.md
# Circular Pass-Window Locator

This block takes a pass/fail vector that covers one full delay period and finds the run of passing entries anchored on a caller-supplied right marker. The vector is treated as circular: indices may run up to almost twice the period, and each access uses the index modulo the period length. The block does not look for the widest passing run. It resolves the right end of the window from the right marker first, then walks left from that end to find where the window begins.

A caller loads the vector as one parallel word together with two limits: a low limit, which also serves as the left marker, and a high limit, which also serves as the right marker. It then pulses a start strobe. The block examines one vector entry per clock. It first counts the passes over the whole period, then runs the right-end scan, then the left-end scan. When it finishes it reports the window endpoints and two signed distances: how far the right end lies beyond the high limit, and how far the left end lies below the low limit. A one-cycle done pulse marks the result. An error flag covers bad limits, vectors with no usable window, and windows that span the whole period.

Top module: `pwl_locator`

## Requirements
- R1: After reset, done_o and err_o are 0, and win_lo_o, win_hi_o, hi_diff_o and lo_diff_o are all 0.
- R2: A vector bit of 1 marks a fail and a bit of 0 marks a pass. The request is rejected with err_o unless lo_lim_i <= 63, hi_lim_i >= lo_lim_i and hi_lim_i <= 127.
- R3: A vector with no pass at all is an error. A vector with no fail at all is also an error, because the window would span the full period.
- R4: If the entry at hi_lim_i mod 64 passes, the block scans upward for the first fail. The scan stops at 127 when hi_lim_i > 63 and at hi_lim_i + 63 otherwise, and every index is taken mod 64. The window's right end is the fail index minus one. No fail within the limit is an error.
- R5: If the entry at hi_lim_i fails, the block scans downward for the first pass. The scan stops at hi_lim_i - 63 when hi_lim_i > 63 and at 0 otherwise. The window's right end is that pass index. No pass within the limit is an error.
- R6: From the right end, the block scans downward for a fail. The scan stops at right end - 63 when the right end is > 63 and at 0 otherwise. The window's left end is the fail index plus one. No fail within the limit is an error.
- R7: On success, hi_diff_o = right end - hi_lim_i and lo_diff_o = lo_lim_i - left end, both as 8-bit two's complement values. win_lo_o and win_hi_o carry the unreduced endpoint indices.
- R8: done_o is high for exactly one cycle per accepted request. err_o is set in that cycle and holds until the next accepted start. On an error, all four result outputs read 0.
- R9: start_i is ignored while a request is in progress, and the vector and limits are captured only at the accepted start.
- R10: A request with bad limits shows done_o in the cycle right after the accepting edge. A request with no pass or no fail shows done_o 64 cycles after that. Any request that reaches a window result takes at least 66 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when idle |
| vec_i | input | 64 | Pass/fail vector, bit set = fail |
| lo_lim_i | input | 8 | Low limit / left marker |
| hi_lim_i | input | 8 | High limit / right marker |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error, held until next accepted start |
| win_lo_o | output | 8 | Window left end index |
| win_hi_o | output | 8 | Window right end index |
| hi_diff_o | output | 8 | Right end minus high limit, signed |
| lo_diff_o | output | 8 | Low limit minus left end, signed |

## Verification
Two things can land on the same cycle. The first is a new start strobe while the scan is still running; the second is the completion edge, where the done pulse, the error flag and the result registers all update together. The bench raises a second start with a different vector during the count phase and checks that the result still matches the first request. It also drives error cases in every phase and checks that the results read zero, that the flag and the pulse coincide, and that the flag persists after the pulse. Random windows placed anywhere on the circle, including across the wrap point, are compared against a bench model of the scan rules.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_SCAN_R,
    ST_SCAN_L,
    ST_DONE
  } pwl_state_e;
endpackage

// File: rtl/pwl_param_check.sv
module pwl_param_check #(
  parameter int N_TAPS = 64,
  parameter int POS_W  = 8
) (
  input  logic [POS_W-1:0] lo_i,
  input  logic [POS_W-1:0] hi_i,
  output logic             ok_o
);
  localparam logic [POS_W:0] LAST = (POS_W+1)'(N_TAPS - 1);
  localparam logic [POS_W:0] TOP  = (POS_W+1)'(2 * N_TAPS - 1);

  logic [POS_W:0] lo_x, hi_x;
  assign lo_x = {1'b0, lo_i};
  assign hi_x = {1'b0, hi_i};
  assign ok_o = (lo_x <= LAST) && (hi_x >= lo_x) && (hi_x <= TOP);
endmodule

// File: rtl/pwl_pass_count.sv
module pwl_pass_count #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwl_scan_limit.sv
module pwl_scan_limit #(
  parameter int N_TAPS = 64,
  parameter int IDX_W  = 9
) (
  input  logic signed [IDX_W-1:0] anchor_i,
  input  logic                    up_i,
  output logic signed [IDX_W-1:0] lim_o
);
  localparam logic signed [IDX_W-1:0] LAST = IDX_W'(N_TAPS - 1);
  localparam logic signed [IDX_W-1:0] TOP  = IDX_W'(2 * N_TAPS - 1);

  always_comb begin
    if (up_i) lim_o = (anchor_i > LAST) ? TOP : anchor_i + LAST;
    else      lim_o = (anchor_i > LAST) ? anchor_i - LAST : '0;
  end
endmodule

// File: rtl/pwl_locator.sv
module pwl_locator
  import pwl_pkg::*;
#(
  parameter int N_TAPS = 64,
  parameter int POS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_TAPS-1:0] vec_i,
  input  logic [POS_W-1:0]  lo_lim_i,
  input  logic [POS_W-1:0]  hi_lim_i,
  output logic              done_o,
  output logic              err_o,
  output logic [POS_W-1:0]  win_lo_o,
  output logic [POS_W-1:0]  win_hi_o,
  output logic [POS_W-1:0]  hi_diff_o,
  output logic [POS_W-1:0]  lo_diff_o
);
  localparam int SEL_W = $clog2(N_TAPS);
  localparam int IDX_W = POS_W + 1;
  localparam int CNT_W = $clog2(N_TAPS + 1);
  localparam logic signed [IDX_W-1:0] LAST_IDX = IDX_W'(N_TAPS - 1);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(N_TAPS);

  pwl_state_e              state_q;
  logic [N_TAPS-1:0]       vec_q;
  logic [POS_W-1:0]        lo_q, hi_q;
  logic signed [IDX_W-1:0] cur_q, wr_q;
  logic                    up_q;
  logic                    params_ok, fail_now;
  logic [CNT_W-1:0]        pass_cnt;
  logic [CNT_W:0]          pass_total;
  logic signed [IDX_W-1:0] hi_x, lo_x, lim_r, lim_l, left_end;

  assign hi_x       = $signed({1'b0, hi_q});
  assign lo_x       = $signed({1'b0, lo_q});
  assign fail_now   = vec_q[cur_q[SEL_W-1:0]];
  assign pass_total = {1'b0, pass_cnt} + {{CNT_W{1'b0}}, ~fail_now};
  assign left_end   = cur_q + 1'b1;

  pwl_param_check #(.N_TAPS(N_TAPS), .POS_W(POS_W)) u_check (
    .lo_i(lo_lim_i), .hi_i(hi_lim_i), .ok_o(params_ok)
  );

  pwl_pass_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q == ST_IDLE),
    .en_i((state_q == ST_COUNT) && !fail_now),
    .cnt_o(pass_cnt)
  );

  pwl_scan_limit #(.N_TAPS(N_TAPS), .IDX_W(IDX_W)) u_lim_r (
    .anchor_i(hi_x), .up_i(up_q), .lim_o(lim_r)
  );

  pwl_scan_limit #(.N_TAPS(N_TAPS), .IDX_W(IDX_W)) u_lim_l (
    .anchor_i(wr_q), .up_i(1'b0), .lim_o(lim_l)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vec_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      cur_q     <= '0;
      wr_q      <= '0;
      up_q      <= 1'b0;
      err_o     <= 1'b0;
      win_lo_o  <= '0;
      win_hi_o  <= '0;
      hi_diff_o <= '0;
      lo_diff_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vec_q     <= vec_i;
          lo_q      <= lo_lim_i;
          hi_q      <= hi_lim_i;
          cur_q     <= '0;
          win_lo_o  <= '0;
          win_hi_o  <= '0;
          hi_diff_o <= '0;
          lo_diff_o <= '0;
          err_o     <= !params_ok;
          state_q   <= params_ok ? ST_COUNT : ST_DONE;
        end
        ST_COUNT: begin
          if (cur_q == LAST_IDX) begin
            if (pass_total == '0 || pass_total == FULL) begin
              err_o   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              cur_q   <= hi_x;
              up_q    <= !vec_q[hi_q[SEL_W-1:0]];
              state_q <= ST_SCAN_R;
            end
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        ST_SCAN_R: begin
          if (up_q) begin
            if (cur_q > lim_r) begin
              err_o   <= 1'b1;
              state_q <= ST_DONE;
            end else if (fail_now) begin
              wr_q    <= cur_q - 1'b1;
              cur_q   <= cur_q - 1'b1;
              state_q <= ST_SCAN_L;
            end else begin
              cur_q <= cur_q + 1'b1;
            end
          end else begin
            if (cur_q < lim_r) begin
              err_o   <= 1'b1;
              state_q <= ST_DONE;
            end else if (!fail_now) begin
              wr_q    <= cur_q;
              state_q <= ST_SCAN_L;
            end else begin
              cur_q <= cur_q - 1'b1;
            end
          end
        end
        ST_SCAN_L: begin
          if (cur_q < lim_l) begin
            err_o   <= 1'b1;
            state_q <= ST_DONE;
          end else if (fail_now) begin
            win_lo_o  <= left_end[POS_W-1:0];
            win_hi_o  <= wr_q[POS_W-1:0];
            hi_diff_o <= POS_W'(wr_q - hi_x);
            lo_diff_o <= POS_W'(lo_x - left_end);
            state_q   <= ST_DONE;
          end else begin
            cur_q <= cur_q - 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/pwl_locator_chk.sv
module pwl_locator_chk #(
  parameter int N_TAPS = 64,
  parameter int POS_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic             err_o,
  input logic [POS_W-1:0] win_lo_o,
  input logic [POS_W-1:0] win_hi_o,
  input logic [POS_W-1:0] hi_diff_o,
  input logic [POS_W-1:0] lo_diff_o
);
  logic [POS_W:0] span;
  assign span = {1'b0, win_hi_o} - {1'b0, win_lo_o};

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);

  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  assert_zero_on_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (win_lo_o == '0 && win_hi_o == '0 &&
                          hi_diff_o == '0 && lo_diff_o == '0));

  assert_window_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (win_hi_o >= win_lo_o && span < (POS_W+1)'(N_TAPS)));
endmodule

bind pwl_locator pwl_locator_chk #(.N_TAPS(N_TAPS), .POS_W(POS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .err_o(err_o), .win_lo_o(win_lo_o), .win_hi_o(win_hi_o),
  .hi_diff_o(hi_diff_o), .lo_diff_o(lo_diff_o)
);

// File: tb/pwl_locator_bench.sv
`timescale 1ns/1ps
module pwl_locator_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] vec_i = '0;
  logic [7:0]  lo_lim_i = '0, hi_lim_i = '0;
  logic        done_o, err_o;
  logic [7:0]  win_lo_o, win_hi_o, hi_diff_o, lo_diff_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  pwl_locator u_pwl_locator (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vec_i(vec_i),
    .lo_lim_i(lo_lim_i), .hi_lim_i(hi_lim_i), .done_o(done_o), .err_o(err_o),
    .win_lo_o(win_lo_o), .win_hi_o(win_hi_o), .hi_diff_o(hi_diff_o),
    .lo_diff_o(lo_diff_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_pass(input logic [63:0] v, input int i);
    return !v[i % 64];
  endfunction

  // expected result from the scan rules
  function automatic void model(input logic [63:0] v, input int lo, input int hi,
                                output bit e, output int wl, output int wr);
    int pc, c, lmt;
    e = 0; wl = 0; wr = 0;
    if (lo > 63 || hi < lo || hi > 127) begin e = 1; return; end
    pc = 0;
    for (int i = 0; i < 64; i++) if (!v[i]) pc++;
    if (pc == 0 || pc == 64) begin e = 1; return; end
    c = hi;
    if (is_pass(v, hi)) begin
      lmt = (hi > 63) ? 127 : hi + 63;
      while (c <= lmt && is_pass(v, c)) c++;
      if (c > lmt) begin e = 1; return; end
      wr = c - 1;
    end else begin
      lmt = (hi > 63) ? hi - 63 : 0;
      while (c >= lmt && !is_pass(v, c)) c--;
      if (c < lmt) begin e = 1; return; end
      wr = c;
    end
    lmt = (wr > 63) ? wr - 63 : 0;
    c = wr;
    while (c >= lmt && is_pass(v, c)) c--;
    if (c < lmt) begin e = 1; return; end
    wl = c + 1;
  endfunction

  function automatic logic [63:0] window(input int s, input int len);
    logic [63:0] v = '1;
    for (int k = 0; k < len; k++) v[(s + k) % 64] = 1'b0;
    return v;
  endfunction

  task automatic pulse_start(input logic [63:0] v, input int lo, input int hi);
    @(negedge clk_i);
    vec_i = v; lo_lim_i = 8'(lo); hi_lim_i = 8'(hi); start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    forever begin
      @(negedge clk_i);
      if (done_o || lat > 400) break;
      lat++;
    end
  endtask

  task automatic judge(input logic [63:0] v, input int lo, input int hi, input string req);
    bit e; int wl, wr;
    model(v, lo, hi, e, wl, wr);
    chk(req, "done", int'(done_o), 1);
    chk(req, "err", int'(err_o), int'(e));
    if (!e) begin
      chk(req, "win_lo", int'(win_lo_o), wl);
      chk(req, "win_hi", int'(win_hi_o), wr);
      chk("R7", "hi_diff", int'($signed(hi_diff_o)), wr - hi);
      chk("R7", "lo_diff", int'($signed(lo_diff_o)), lo - wl);
    end else begin
      chk("R8", "zero results", int'({win_lo_o, win_hi_o, hi_diff_o, lo_diff_o}), 0);
    end
    @(negedge clk_i);
    chk("R8", "done pulse width", int'(done_o), 0);
    chk("R8", "err held", int'(err_o), int'(e));
  endtask

  task automatic run_case(input logic [63:0] v, input int lo, input int hi,
                          input string req, output int lat);
    pulse_start(v, lo, hi);
    wait_done(lat);
    judge(v, lo, hi, req);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] va, vb;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "err", int'(err_o), 0);
    chk("R1", "results", int'({win_lo_o, win_hi_o, hi_diff_o, lo_diff_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 / R10 bad limits
    run_case(window(20, 10), 64, 70, "R2", lat);  chk("R10", "bad-limit latency", lat, 0);
    run_case(window(20, 10), 10, 5, "R2", lat);   chk("R10", "bad-limit latency", lat, 0);
    run_case(window(20, 10), 0, 128, "R2", lat);  chk("R10", "bad-limit latency", lat, 0);

    // R3 all fail / all pass
    run_case('1, 5, 10, "R3", lat); chk("R10", "all-fail latency", lat, 64);
    run_case('0, 5, 10, "R3", lat); chk("R10", "all-pass latency", lat, 64);

    // R4 pass at marker: window 20..40, expect wr=40 wl=20
    run_case(window(20, 21), 25, 30, "R4", lat);
    chk("R4", "right end", int'(win_hi_o), 40);
    chk("R10", "valid latency >= 66", int'(lat >= 66), 1);
    // R5 fail at marker, scan down: hi_diff = -10
    run_case(window(20, 21), 25, 50, "R5", lat);
    chk("R5", "hi_diff", int'($signed(hi_diff_o)), -10);
    // R4 wrap: window 60..5, hi=66, expect wr=69 wl=60
    run_case(window(60, 10), 61, 66, "R4", lat);
    chk("R4", "wrap right end", int'(win_hi_o), 69);
    chk("R6", "wrap left end", int'(win_lo_o), 60);
    // R5 no pass below marker -> error
    run_case(window(50, 6), 5, 10, "R5", lat);
    chk("R5", "error", int'(err_o), 1);
    // R6 left scan hits limit 0 -> error
    run_case(window(0, 6), 1, 3, "R6", lat);
    chk("R6", "error", int'(err_o), 1);
    // R4 upward limit 127 reached without fail -> error
    va = '0; va[20] = 1'b1;
    run_case(va, 40, 100, "R4", lat);
    chk("R4", "limit error", int'(err_o), 1);

    // R9 start while busy ignored
    va = window(10, 15); vb = window(40, 8);
    pulse_start(va, 12, 20);
    repeat (10) @(negedge clk_i);
    vec_i = vb; lo_lim_i = 8'd41; hi_lim_i = 8'd44; start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
    wait_done(lat);
    judge(va, 12, 20, "R9");
    chk("R9", "no second done", int'(done_o), 0);

    // random mix
    for (int n = 0; n < 160; n++) begin
      int s, len, lo, hi;
      logic [63:0] v;
      s = int'($urandom_range(0, 63));
      len = int'($urandom_range(1, 50));
      v = window(s, len);
      if ($urandom_range(0, 3) == 0) v = v & 64'($urandom()) & 64'($urandom());
      lo = int'($urandom_range(0, 63));
      hi = int'($urandom_range(lo, 127));
      if ($urandom_range(0, 15) == 0) lo = int'($urandom_range(0, 255));
      run_case(v, lo, hi, "R4 R5 R6 R7", lat);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule